// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits on the control port of a tile-based video processor. Each 32-bit write carries a command code in bits 31:24 and parameters in bits 23:0. The decoder keeps a shadow copy of the most recent word written to each low-numbered command. From these writes it maintains a 32-bit status word, the display start position, and the horizontal and vertical display ranges. It reports changes with single-cycle pulses so that the display-dimension logic can recompute only when something moved.

Query commands load a readback register. The value comes either from a masked copy of one of the eight drawing-environment registers, which the drawing side supplies as an input array, or from a fixed constant. Two commands also raise a pulse that tells the command queue to flush and to drop any partial rectangle transfer. One write is accepted per clock, and every output is registered, so each effect appears one clock after the write.

Top module: `disp_ctl_decoder`

## Requirements
- R1: While `rst_n` is low, `status` is 0x14802000, `readback` is 0, the display start and both ranges are 0, and every pulse output is low.
- R2: A write with command 0x00 returns `status` to 0x14802000 and `readback` to 0, and pulses `fifo_flush`. It clears every shadow to zero except shadow 3, which becomes 1. It leaves the display start and ranges unchanged, so a following range write equal to the one before the reset is accepted again.
- R3: A write with command 0x01 pulses `fifo_flush` for one cycle and leaves `status`, `readback`, the start position and the ranges unchanged. It is never suppressed.
- R4: For commands 2 to NUM_SHADOW-1, other than 5, a write whose full 32-bit word equals the stored shadow is ignored. It raises no pulse and changes no output.
- R5: Command 0x03 copies data bit 0 into status bit 23, the blanking flag.
- R6: Command 0x04 copies data bits 1:0 into status bits 30:29, the DMA-direction field.
- R7: Command 0x05 loads the start X from data bits 9:0 and the start Y from data bits 18:10. It pulses `start_chg` only when X or Y actually differs from the stored value, and this comparison is made even when the word repeats.
- R8: Command 0x06 loads `h_x1` from data bits 11:0 and `h_x2` from data bits 23:12, and pulses `hrange_chg`.
- R9: Command 0x07 loads `v_y1` from data bits 9:0 and `v_y2` from data bits 19:10, and pulses `vrange_chg`.
- R10: Command 0x08 writes data bits 5:0 into status bits 22:17 and data bit 6 into status bit 16, and pulses `mode_chg`. All other status bits are kept.
- R11: Commands 0x10 to 0x1F are queries keyed on data bits 3:0. Codes 2, 3 and 4 load `readback` with environment register (code) ANDed with 0x000FFFFF. Code 5 loads environment register 5 ANDed with 0x003FFFFF. Code 7 loads 2. Any other code leaves `readback` unchanged.
- R12: Every effect is visible one clock after the write. At most one of the four change pulses is high in any cycle. Commands with no function (for example 0x09) change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control write strobe, one word per cycle |
| wr_data | input | 32 | Command in bits 31:24, parameters below |
| env_regs | input | 8x32 | Drawing-environment registers, index 0..7 |
| status | output | 32 | Status word |
| readback | output | 32 | Query result register |
| start_x | output | 10 | Display start X |
| start_y | output | 9 | Display start Y |
| h_x1 | output | 12 | Horizontal range start |
| h_x2 | output | 12 | Horizontal range end |
| v_y1 | output | 10 | Vertical range start |
| v_y2 | output | 10 | Vertical range end |
| start_chg | output | 1 | Start position changed |
| hrange_chg | output | 1 | Horizontal range loaded |
| vrange_chg | output | 1 | Vertical range loaded |
| mode_chg | output | 1 | Mode bits loaded |
| fifo_flush | output | 1 | Flush command queue and abort rectangle transfer |

## Verification
The assertions take for granted that `wr_data` is a defined value whenever `wr_en` is high. They also assume that a redundant write finds its status field already equal to the data, which holds because each field is written only through its own command or through a reset. The environment array is assumed to stay stable across a query. The stimulus changes `env_regs` and `wr_data` only on the falling edge, keeps each write one cycle long, and reaches the shadows only through commands, so these conditions hold throughout the run.

// File: rtl/disp_ctl_decoder.sv
module disp_ctl_decoder #(
  parameter int          NUM_SHADOW   = 16,
  parameter logic [31:0] RESET_STATUS = 32'h1480_2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic [7:0][31:0] env_regs,
  output logic [31:0]     status,
  output logic [31:0]     readback,
  output logic [9:0]      start_x,
  output logic [8:0]      start_y,
  output logic [11:0]     h_x1,
  output logic [11:0]     h_x2,
  output logic [9:0]      v_y1,
  output logic [9:0]      v_y2,
  output logic            start_chg,
  output logic            hrange_chg,
  output logic            vrange_chg,
  output logic            mode_chg,
  output logic            fifo_flush
);
  localparam int SIW = $clog2(NUM_SHADOW);
  localparam int BLANK_BIT = 23;
  localparam int DMA_LO = 29;
  localparam logic [31:0] MASK20 = 32'h000F_FFFF;
  localparam logic [31:0] MASK22 = 32'h003F_FFFF;

  logic [31:0] shadow [NUM_SHADOW];

  logic [7:0]     cmd;
  logic [SIW-1:0] sidx;
  logic           in_shadow, redundant, accept, start_diff;

  assign cmd        = wr_data[31:24];
  assign sidx       = cmd[SIW-1:0];
  assign in_shadow  = 32'(cmd) < NUM_SHADOW;
  assign redundant  = in_shadow && cmd > 8'h01 && cmd != 8'h05 && shadow[sidx] == wr_data;
  assign accept     = wr_en && !redundant;
  assign start_diff = wr_data[9:0] != start_x || wr_data[18:10] != start_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SHADOW; i++) shadow[i] <= (i == 3) ? 32'd1 : 32'd0;
      status     <= RESET_STATUS;
      readback   <= '0;
      start_x    <= '0;
      start_y    <= '0;
      h_x1       <= '0;
      h_x2       <= '0;
      v_y1       <= '0;
      v_y2       <= '0;
      start_chg  <= 1'b0;
      hrange_chg <= 1'b0;
      vrange_chg <= 1'b0;
      mode_chg   <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      start_chg  <= 1'b0;
      hrange_chg <= 1'b0;
      vrange_chg <= 1'b0;
      mode_chg   <= 1'b0;
      fifo_flush <= 1'b0;
      if (accept) begin
        if (in_shadow) shadow[sidx] <= wr_data;
        case (cmd)
          8'h00: begin
            for (int i = 0; i < NUM_SHADOW; i++) shadow[i] <= (i == 3) ? 32'd1 : 32'd0;
            status     <= RESET_STATUS;
            readback   <= '0;
            fifo_flush <= 1'b1;
          end
          8'h01: fifo_flush <= 1'b1;
          8'h03: status[BLANK_BIT] <= wr_data[0];
          8'h04: status[DMA_LO+1:DMA_LO] <= wr_data[1:0];
          8'h05: if (start_diff) begin
            start_x   <= wr_data[9:0];
            start_y   <= wr_data[18:10];
            start_chg <= 1'b1;
          end
          8'h06: begin
            h_x1       <= wr_data[11:0];
            h_x2       <= wr_data[23:12];
            hrange_chg <= 1'b1;
          end
          8'h07: begin
            v_y1       <= wr_data[9:0];
            v_y2       <= wr_data[19:10];
            vrange_chg <= 1'b1;
          end
          8'h08: begin
            status[22:16] <= {wr_data[5:0], wr_data[6]};
            mode_chg      <= 1'b1;
          end
          default: if (cmd[7:4] == 4'h1) begin
            case (wr_data[3:0])
              4'h2, 4'h3, 4'h4: readback <= env_regs[wr_data[2:0]] & MASK20;
              4'h5:             readback <= env_regs[5] & MASK22;
              4'h7:             readback <= 32'd2;
              default:          ;
            endcase
          end
        endcase
      end
    end
  end

  AST_CMD0_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'h00) |=> (status == RESET_STATUS && readback == 32'd0 && fifo_flush)); // R2
  AST_FLUSH_CMD1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'h01) |=> (fifo_flush && $stable(status) && $stable(readback))); // R3
  AST_BLANK_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'h03) |=> status[BLANK_BIT] == $past(wr_data[0])); // R5
  AST_DMA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'h04) |=> status[DMA_LO+1:DMA_LO] == $past(wr_data[1:0])); // R6
  AST_START_REAL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start_chg |-> {start_x, start_y} != $past({start_x, start_y})); // R7
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cmd == 8'h05) |=> $stable({start_x, start_y})); // R7
  AST_HRANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cmd == 8'h06) |=> $stable({h_x1, h_x2})); // R8
  AST_VRANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cmd == 8'h07) |=> $stable({v_y1, v_y2})); // R9
  AST_MODE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == 8'h08) |=> status[22:16] == {$past(wr_data[5:0]), $past(wr_data[6])}); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_chg, hrange_chg, vrange_chg, mode_chg})); // R12
endmodule

// File: tb/disp_ctl_decoder_tb.sv
module disp_ctl_decoder_tb;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [7:0][31:0] env_regs;
  logic [31:0]     status, readback;
  logic [9:0]      start_x;
  logic [8:0]      start_y;
  logic [11:0]     h_x1, h_x2;
  logic [9:0]      v_y1, v_y2;
  logic            start_chg, hrange_chg, vrange_chg, mode_chg, fifo_flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_ctl_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .env_regs(env_regs),
    .status(status), .readback(readback), .start_x(start_x), .start_y(start_y),
    .h_x1(h_x1), .h_x2(h_x2), .v_y1(v_y1), .v_y2(v_y2),
    .start_chg(start_chg), .hrange_chg(hrange_chg), .vrange_chg(vrange_chg),
    .mode_chg(mode_chg), .fifo_flush(fifo_flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status", status, 32'h1480_2000);
    check("R1 readback", readback, 32'd0);
    check("R1 position", {22'd0, start_x, start_y}, 32'd0);
    check("R1 ranges", {h_x1, h_x2, 8'd0}, 32'd0);
    check("R1 vranges", {12'd0, v_y1, v_y2}, 32'd0);
    check("R1 pulses", {27'd0, start_chg, hrange_chg, vrange_chg, mode_chg, fifo_flush}, 32'd0);
  endtask

  task automatic t_flush;
    wr(32'h0100_0000);
    check("R3 flush pulse", {31'd0, fifo_flush}, 32'd1);
    check("R3 status kept", status, 32'h1480_2000);
    wr(32'h0100_0000);
    check("R3 repeat not suppressed", {31'd0, fifo_flush}, 32'd1);
    @(negedge clk);
    check("R3 pulse one cycle", {31'd0, fifo_flush}, 32'd0);
  endtask

  task automatic t_blank;
    wr(32'h0300_0000);
    check("R5 blank clear", status, 32'h1400_2000);
    wr(32'h0300_0001);
    check("R5 blank set", status, 32'h1480_2000);
  endtask

  task automatic t_dma;
    wr(32'h0400_0002);
    check("R6 dma 2", status, 32'h5480_2000);
    wr(32'h04FF_FFFF);
    check("R6 dma 3", status, 32'h7480_2000);
    wr(32'h0400_0000);
    check("R6 dma 0", status, 32'h1480_2000);
  endtask

  task automatic t_start;
    wr(32'h0500_0000 | (32'h0AA << 10) | 32'h155);
    check("R7 start_chg", {31'd0, start_chg}, 32'd1);
    check("R7 start_x", {22'd0, start_x}, 32'h155);
    check("R7 start_y", {23'd0, start_y}, 32'h0AA);
    wr(32'h0500_0000 | (32'h0AA << 10) | 32'h155);
    check("R7 same value no pulse", {31'd0, start_chg}, 32'd0);
    wr(32'h0500_0000 | (32'h1FF << 10) | 32'h155);
    check("R7 y-only change pulse", {31'd0, start_chg}, 32'd1);
    check("R7 new y", {23'd0, start_y}, 32'h1FF);
  endtask

  task automatic t_ranges;
    wr(32'h06C6_0260);
    check("R8 hrange pulse", {31'd0, hrange_chg}, 32'd1);
    check("R8 x1", {20'd0, h_x1}, 32'h260);
    check("R8 x2", {20'd0, h_x2}, 32'hC60);
    wr(32'h06C6_0260);
    check("R4 repeat range no pulse", {31'd0, hrange_chg}, 32'd0);
    wr(32'h0704_0010);
    check("R9 vrange pulse", {31'd0, vrange_chg}, 32'd1);
    check("R9 y1", {22'd0, v_y1}, 32'h010);
    check("R9 y2", {22'd0, v_y2}, 32'h100);
  endtask

  task automatic t_mode;
    wr(32'h0800_0045);
    check("R10 mode pulse", {31'd0, mode_chg}, 32'd1);
    check("R10 status mode", status, 32'h148B_2000);
    wr(32'h0800_0045);
    check("R4 repeat mode no pulse", {31'd0, mode_chg}, 32'd0);
    check("R4 repeat mode status", status, 32'h148B_2000);
    wr(32'h0800_003F);
    check("R10 status mode2", status, 32'h14FE_2000);
  endtask

  task automatic t_nop;
    wr(32'h0900_0123);
    check("R12 unused cmd status", status, 32'h14FE_2000);
    check("R12 unused cmd pulses", {28'd0, start_chg, hrange_chg, vrange_chg, mode_chg}, 32'd0);
  endtask

  task automatic t_query;
    wr(32'h1000_0002);
    check("R11 code2", readback, 32'h000F_FFFF);
    wr(32'h1000_0003);
    check("R11 code3", readback, 32'h0002_3456);
    wr(32'h1F00_0004);
    check("R11 code4", readback, 32'h000B_CDEF);
    wr(32'h1000_0005);
    check("R11 code5", readback, 32'h003F_FFFF);
    wr(32'h1000_0007);
    check("R11 code7", readback, 32'd2);
    wr(32'h1000_0000);
    check("R11 code0 keeps", readback, 32'd2);
    wr(32'h1000_000A);
    check("R11 codeA keeps", readback, 32'd2);
  endtask

  task automatic t_cmd0;
    wr(32'h0000_0000);
    check("R2 status", status, 32'h1480_2000);
    check("R2 readback", readback, 32'd0);
    check("R2 flush", {31'd0, fifo_flush}, 32'd1);
    check("R2 range kept", {20'd0, h_x1}, 32'h260);
    check("R2 start kept", {22'd0, start_x}, 32'h155);
    wr(32'h06C6_0260);
    check("R2 shadow cleared", {31'd0, hrange_chg}, 32'd1);
  endtask

  initial begin
    env_regs[0] = 32'hE000_0000;
    env_regs[1] = 32'hE100_0000;
    env_regs[2] = 32'hE2FF_FFFF;
    env_regs[3] = 32'hE312_3456;
    env_regs[4] = 32'hE4AB_CDEF;
    env_regs[5] = 32'hE5FF_FFFF;
    env_regs[6] = 32'hE600_0000;
    env_regs[7] = 32'hE700_0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_flush();
    t_blank();
    t_dma();
    t_start();
    t_ranges();
    t_mode();
    t_nop();
    t_query();
    t_cmd0();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule